// File: doc/BRIEF.md
# Vector-Immediate Length Decoder with Fetch Redirect

This block sits in the length-decode stage of a processor front end that fetches 64 bits per cycle. Each cycle it takes a fetch group of 32-bit words and marks where instructions start. A plain instruction takes one word. A prefixed instruction takes two words, and its second word may fall in the next fetch group. One kind of prefixed instruction carries a trailing vector of immediate values, so its real length depends on the vector parameters held in the prefix. The start marker treats that instruction as an 8-byte instruction and clears every later slot of the group, as it would after a taken unconditional jump.

One cycle later the block works out the true byte length from the element widths, the sub-vector length and the maximum vector length. It then writes the resulting next address into the branch-target buffer, keyed by the instruction's address, so that later fetches of the same code are steered correctly by speculation. When the next address is not simply the instruction address plus 8, the block also raises a one-cycle fetch redirect and flushes the group that is already in flight behind the instruction.

Top module: `vecimm_len_redirect`

## Requirements
- R1: With no prefix pending, each plain word in a valid group is marked as a start with the long flag clear. A word is prefixed when bits [31:26] equal the prefix opcode, which is 1 by default. Slot i is bits [32i+31:32i] and has address group_pc + 4i.
- R2: A prefixed word is marked as a start with the long flag set. The word after it is not a start, whether it is the next slot or slot 0 of the next valid group.
- R3: A prefixed word with bit 25 set is a vector-immediate start, and every later slot of the same group is cleared.
- R4: The vector-immediate length is round_up_4(E*S*M - 2 + 8). E is the larger element size in bytes of the two 2-bit width fields, source at [23:22] and destination at [21:20], where 00=8, 01=4, 10=2 and 11=1. S-1 sits at [19:18] and M-1 at [17:12]. The target is the instruction address plus this length.
- R5: The redirect and flush for a vector-immediate instruction are asserted in the cycle after its group is presented, for exactly one cycle.
- R6: In that same cycle the BTB write strobe is raised, with the instruction address and the computed target. This happens whether or not a redirect is issued, and the redirect target equals the BTB target.
- R7: When the target equals the instruction address plus 8, no redirect and no flush are issued.
- R8: In a flush cycle the presented group produces no starts and no vector-immediate capture, and any pending suffix is cleared.
- R9: A group with the valid input low produces no starts and no later BTB write.
- R10: After reset all starts, redirect, flush and BTB write outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| grp_vld_i | input | 1 | Fetch group valid |
| grp_pc_i | input | ADDR_W | Address of slot 0 |
| grp_data_i | input | FETCH_W | Fetch group words, slot 0 in the low bits |
| slot_start_o | output | FETCH_W/32 | Slot begins an instruction |
| slot_long_o | output | FETCH_W/32 | Started slot is a prefixed (8-byte) instruction |
| redir_vld_o | output | 1 | Fetch redirect request |
| redir_pc_o | output | ADDR_W | Redirect target |
| flush_o | output | 1 | Flush the in-flight group |
| btb_we_o | output | 1 | BTB write strobe |
| btb_pc_o | output | ADDR_W | BTB write key (instruction address) |
| btb_tgt_o | output | ADDR_W | BTB write target |

## Verification
Start and long flags are combinational in the presented group and the pending-suffix state, so the bench drives each group just after a falling edge and reads the flags one nanosecond later, in the same cycle. Redirect, flush and BTB outputs come from a single register stage, so they belong to the group applied one cycle earlier. The bench reads them after the next falling-edge drive, while it also checks that the newly presented group was flushed or kept as required. It reads them once more a cycle later to confirm that the strobes last a single cycle.

// File: rtl/vid_pkg.sv
`timescale 1ns/1ps
package vid_pkg;
   localparam int WORD_W    = 32;
   localparam int OPC_LO    = 26;
   localparam int OPC_W     = 6;
   localparam int VIMM_BIT  = 25;
   localparam int SRCW_LO   = 22;
   localparam int DSTW_LO   = 20;
   localparam int SUBVL_LO  = 18;
   localparam int MVL_LO    = 12;
   localparam int MVL_W     = 6;
   localparam int LEN_W     = MVL_W + 6;

   typedef struct packed {
      logic [1:0]       src_w;
      logic [1:0]       dst_w;
      logic [1:0]       subvl_m1;
      logic [MVL_W-1:0] maxvl_m1;
   } vfield_t;
endpackage

// File: rtl/vid_slot_mark.sv
`timescale 1ns/1ps
module vid_slot_mark
   import vid_pkg::*;
#(
   parameter int         NSLOT   = 2,
   parameter logic [5:0] PFX_OPC = 6'd1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    vld_i,
   input  logic [NSLOT*WORD_W-1:0] data_i,
   input  logic                    flush_i,
   output logic [NSLOT-1:0]        start_o,
   output logic [NSLOT-1:0]        long_o,
   output logic [NSLOT-1:0]        vimm_o
);
   logic [NSLOT-1:0] is_pfx;
   logic [NSLOT-1:0] is_vimm;
   logic             pend_q;
   logic             pend_next;

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      logic [WORD_W-1:0] w;
      logic              unused_tail;
      assign w           = data_i[i*WORD_W +: WORD_W];
      assign is_pfx[i]   = (w[OPC_LO +: OPC_W] == PFX_OPC);
      assign is_vimm[i]  = is_pfx[i] & w[VIMM_BIT];
      assign unused_tail = ^w[VIMM_BIT-1:0];
   end

   always_comb begin
      logic cov;
      logic kill;
      cov  = pend_q;
      kill = 1'b0;
      for (int i = 0; i < NSLOT; i++) begin
         start_o[i] = vld_i & ~flush_i & ~cov & ~kill;
         long_o[i]  = start_o[i] & is_pfx[i];
         vimm_o[i]  = start_o[i] & is_vimm[i];
         kill       = kill | vimm_o[i];
         cov        = long_o[i];
      end
      pend_next = cov;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend_q <= 1'b0;
      else if (flush_i) pend_q <= 1'b0;
      else if (vld_i)   pend_q <= pend_next;
   end
endmodule

// File: rtl/vid_len_calc.sv
`timescale 1ns/1ps
module vid_len_calc
   import vid_pkg::*;
#(
   parameter bit SHIFT_SCALE = 1'b1
) (
   input  vfield_t          fld_i,
   output logic [LEN_W-1:0] len_o
);
   logic [1:0]       wmin;
   logic [LEN_W-1:0] sv;
   logic [LEN_W-1:0] mv;
   logic [LEN_W-1:0] cnt;
   logic [LEN_W-1:0] payload;
   logic [LEN_W-1:0] total;

   assign wmin = (fld_i.src_w < fld_i.dst_w) ? fld_i.src_w : fld_i.dst_w;
   assign sv   = LEN_W'(fld_i.subvl_m1) + LEN_W'(1);
   assign mv   = LEN_W'(fld_i.maxvl_m1) + LEN_W'(1);
   assign cnt  = sv * mv;

   if (SHIFT_SCALE) begin : g_shift
      assign payload = cnt << (2'd3 - wmin);
   end else begin : g_mul
      logic [3:0] esz;
      assign esz     = 4'd8 >> wmin;
      assign payload = cnt * LEN_W'(esz);
   end

   // minus 2 in-word bytes, plus 8 header bytes, plus 3 for rounding
   assign total = payload + LEN_W'(9);
   assign len_o = {total[LEN_W-1:2], 2'b00};
endmodule

// File: rtl/vid_redirect.sv
`timescale 1ns/1ps
module vid_redirect
   import vid_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter bit SHIFT_SCALE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  vfield_t           fld_i,
   output logic              redir_vld_o,
   output logic [ADDR_W-1:0] redir_pc_o,
   output logic              flush_o,
   output logic              btb_we_o,
   output logic [ADDR_W-1:0] btb_pc_o,
   output logic [ADDR_W-1:0] btb_tgt_o
);
   logic              hit_q;
   logic [ADDR_W-1:0] pc_q;
   vfield_t           fld_q;
   logic [LEN_W-1:0]  len;
   logic [ADDR_W-1:0] tgt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q <= 1'b0;
         pc_q  <= '0;
         fld_q <= '0;
      end else begin
         hit_q <= hit_i;
         if (hit_i) begin
            pc_q  <= pc_i;
            fld_q <= fld_i;
         end
      end
   end

   vid_len_calc #(.SHIFT_SCALE(SHIFT_SCALE)) u_len (
      .fld_i (fld_q),
      .len_o (len)
   );

   assign tgt         = pc_q + ADDR_W'(len);
   assign btb_we_o    = hit_q;
   assign btb_pc_o    = pc_q;
   assign btb_tgt_o   = tgt;
   assign redir_vld_o = hit_q && (len != LEN_W'(8));
   assign redir_pc_o  = tgt;
   assign flush_o     = redir_vld_o;
endmodule

// File: rtl/vecimm_len_redirect.sv
`timescale 1ns/1ps
module vecimm_len_redirect
   import vid_pkg::*;
#(
   parameter int         FETCH_W     = 64,
   parameter int         ADDR_W      = 32,
   parameter logic [5:0] PFX_OPC     = 6'd1,
   parameter bit         SHIFT_SCALE = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      grp_vld_i,
   input  logic [ADDR_W-1:0]         grp_pc_i,
   input  logic [FETCH_W-1:0]        grp_data_i,
   output logic [FETCH_W/32-1:0]     slot_start_o,
   output logic [FETCH_W/32-1:0]     slot_long_o,
   output logic                      redir_vld_o,
   output logic [ADDR_W-1:0]         redir_pc_o,
   output logic                      flush_o,
   output logic                      btb_we_o,
   output logic [ADDR_W-1:0]         btb_pc_o,
   output logic [ADDR_W-1:0]         btb_tgt_o
);
   localparam int NSLOT = FETCH_W / WORD_W;
   localparam int OFF_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

   if ((FETCH_W % WORD_W) != 0 || NSLOT < 2) begin : g_bad_fetch
      $error("FETCH_W must be a multiple of 32 holding at least two words");
   end
   if (ADDR_W < LEN_W + 2) begin : g_bad_addr
      $error("ADDR_W too narrow for the largest instruction length");
   end

   logic [NSLOT-1:0]  vimm_sel;
   logic [WORD_W-1:0] sel_word;
   logic [OFF_W-1:0]  sel_off;
   logic [ADDR_W-1:0] sel_pc;
   vfield_t           sel_fld;
   logic              hit;
   logic              unused_bits;

   vid_slot_mark #(.NSLOT(NSLOT), .PFX_OPC(PFX_OPC)) u_mark (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld_i   (grp_vld_i),
      .data_i  (grp_data_i),
      .flush_i (flush_o),
      .start_o (slot_start_o),
      .long_o  (slot_long_o),
      .vimm_o  (vimm_sel)
   );

   always_comb begin
      sel_word = '0;
      sel_off  = '0;
      for (int i = 0; i < NSLOT; i++) begin
         if (vimm_sel[i]) begin
            sel_word = grp_data_i[i*WORD_W +: WORD_W];
            sel_off  = OFF_W'(i);
         end
      end
   end

   assign sel_fld.src_w    = sel_word[SRCW_LO +: 2];
   assign sel_fld.dst_w    = sel_word[DSTW_LO +: 2];
   assign sel_fld.subvl_m1 = sel_word[SUBVL_LO +: 2];
   assign sel_fld.maxvl_m1 = sel_word[MVL_LO +: MVL_W];
   assign unused_bits      = ^{sel_word[WORD_W-1:SRCW_LO+2], sel_word[MVL_LO-1:0]};
   assign sel_pc           = grp_pc_i + ADDR_W'({sel_off, 2'b00});
   assign hit              = |vimm_sel;

   vid_redirect #(.ADDR_W(ADDR_W), .SHIFT_SCALE(SHIFT_SCALE)) u_redir (
      .clk         (clk),
      .rst_n       (rst_n),
      .hit_i       (hit),
      .pc_i        (sel_pc),
      .fld_i       (sel_fld),
      .redir_vld_o (redir_vld_o),
      .redir_pc_o  (redir_pc_o),
      .flush_o     (flush_o),
      .btb_we_o    (btb_we_o),
      .btb_pc_o    (btb_pc_o),
      .btb_tgt_o   (btb_tgt_o)
   );
endmodule

// File: rtl/vid_checker.sv
`timescale 1ns/1ps
module vid_checker #(
   parameter int NSLOT  = 2,
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              grp_vld_i,
   input logic [NSLOT-1:0]  slot_start_o,
   input logic [NSLOT-1:0]  slot_long_o,
   input logic              redir_vld_o,
   input logic [ADDR_W-1:0] redir_pc_o,
   input logic              flush_o,
   input logic              btb_we_o,
   input logic [ADDR_W-1:0] btb_pc_o,
   input logic [ADDR_W-1:0] btb_tgt_o
);
   logic [ADDR_W-1:0] span;
   assign span = btb_tgt_o - btb_pc_o;

   for (genvar i = 0; i + 1 < NSLOT; i++) begin : g_pair
      a_r2_suffix_not_start: assert property (@(posedge clk) disable iff (!rst_n)
         (slot_start_o[i] && slot_long_o[i]) |-> !slot_start_o[i+1]);
   end

   a_r1_long_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_long_o & ~slot_start_o) == '0);

   a_r4_span_granule: assert property (@(posedge clk) disable iff (!rst_n)
      btb_we_o |-> (span[1:0] == 2'b00 && span >= ADDR_W'(8)));

   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      redir_vld_o |=> !redir_vld_o);

   a_r5_after_group: assert property (@(posedge clk) disable iff (!rst_n)
      btb_we_o |-> $past(grp_vld_i));

   a_r6_btb_with_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      redir_vld_o |-> (btb_we_o && btb_tgt_o == redir_pc_o && flush_o));

   a_r7_no_short_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      redir_vld_o |-> (redir_pc_o != btb_pc_o + ADDR_W'(8)));

   a_r8_flush_clears_marks: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> (slot_start_o == '0));

   a_r9_idle_no_marks: assert property (@(posedge clk) disable iff (!rst_n)
      !grp_vld_i |-> (slot_start_o == '0));
endmodule

bind vecimm_len_redirect vid_checker #(.NSLOT(FETCH_W/32), .ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .grp_vld_i    (grp_vld_i),
   .slot_start_o (slot_start_o),
   .slot_long_o  (slot_long_o),
   .redir_vld_o  (redir_vld_o),
   .redir_pc_o   (redir_pc_o),
   .flush_o      (flush_o),
   .btb_we_o     (btb_we_o),
   .btb_pc_o     (btb_pc_o),
   .btb_tgt_o    (btb_tgt_o)
);

// File: tb/vecimm_len_redirect_tb.sv
`timescale 1ns/1ps
module vecimm_len_redirect_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        grp_vld_i = 1'b0;
   logic [31:0] grp_pc_i = '0;
   logic [63:0] grp_data_i = '0;
   logic [1:0]  slot_start_o, slot_long_o;
   logic        redir_vld_o, flush_o, btb_we_o;
   logic [31:0] redir_pc_o, btb_pc_o, btb_tgt_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   vecimm_len_redirect u_dut (
      .clk(clk), .rst_n(rst_n), .grp_vld_i(grp_vld_i), .grp_pc_i(grp_pc_i),
      .grp_data_i(grp_data_i), .slot_start_o(slot_start_o), .slot_long_o(slot_long_o),
      .redir_vld_o(redir_vld_o), .redir_pc_o(redir_pc_o), .flush_o(flush_o),
      .btb_we_o(btb_we_o), .btb_pc_o(btb_pc_o), .btb_tgt_o(btb_tgt_o)
   );

   function automatic logic [31:0] w_plain();
      return 32'h6000_1234;
   endfunction

   function automatic logic [31:0] w_pfx(bit vimm, int s, int d, int sv, int mv);
      return {6'd1, vimm, 1'b0, 2'(s), 2'(d), 2'(sv), 6'(mv), 12'h0};
   endfunction

   function automatic int bytes_of(int code);
      case (code)
         0: return 8;
         1: return 4;
         2: return 2;
         default: return 1;
      endcase
   endfunction

   function automatic int exp_len(int s, int d, int sv, int mv);
      int e;
      e = (bytes_of(s) > bytes_of(d)) ? bytes_of(s) : bytes_of(d);
      return ((e * (sv + 1) * (mv + 1) - 2 + 8 + 3) / 4) * 4;
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic apply(bit v, logic [31:0] pc, logic [31:0] w0, logic [31:0] w1);
      @(negedge clk);
      grp_vld_i  = v;
      grp_pc_i   = pc;
      grp_data_i = {w1, w0};
      #1;
   endtask

   task automatic t_reset();
      chk("R10 start", 64'(slot_start_o), 0);
      chk("R10 redir", 64'(redir_vld_o), 0);
      chk("R10 flush", 64'(flush_o), 0);
      chk("R10 btb_we", 64'(btb_we_o), 0);
   endtask

   task automatic t_plain();
      apply(1, 32'h40, w_plain(), w_plain());
      chk("R1 start", 64'(slot_start_o), 2'b11);
      chk("R1 long", 64'(slot_long_o), 2'b00);
      apply(0, 32'h48, w_plain(), w_plain());
      chk("R1 no btb", 64'(btb_we_o), 0);
   endtask

   task automatic t_prefix();
      apply(1, 32'h80, w_pfx(0, 0, 0, 0, 0), w_plain());
      chk("R2 slot0 start", 64'(slot_start_o), 2'b01);
      chk("R2 slot0 long", 64'(slot_long_o), 2'b01);
      apply(1, 32'h88, w_plain(), w_plain());
      chk("R2 after pair", 64'(slot_start_o), 2'b11);
      apply(1, 32'hA0, w_plain(), w_pfx(0, 1, 1, 0, 0));
      chk("R2 slot1 start", 64'(slot_start_o), 2'b11);
      chk("R2 slot1 long", 64'(slot_long_o), 2'b10);
      apply(1, 32'hA8, w_plain(), w_plain());
      chk("R2 carried suffix", 64'(slot_start_o), 2'b10);
      apply(0, 32'h0, w_plain(), w_plain());
   endtask

   task automatic t_vimm_slot0();
      apply(1, 32'h10, w_pfx(1, 1, 1, 0, 1), w_plain());
      chk("R3 start", 64'(slot_start_o), 2'b01);
      chk("R3 long", 64'(slot_long_o), 2'b01);
      apply(1, 32'h18, w_plain(), w_plain());
      chk("R5 redir", 64'(redir_vld_o), 1);
      chk("R4 target", 64'(redir_pc_o), 64'(32'h10 + exp_len(1, 1, 0, 1)));
      chk("R5 flush", 64'(flush_o), 1);
      chk("R6 btb_we", 64'(btb_we_o), 1);
      chk("R6 btb_pc", 64'(btb_pc_o), 32'h10);
      chk("R6 btb_tgt", 64'(btb_tgt_o), 64'(32'h10 + exp_len(1, 1, 0, 1)));
      chk("R8 flushed group", 64'(slot_start_o), 2'b00);
      apply(0, 32'h0, w_plain(), w_plain());
      chk("R5 one cycle", 64'(redir_vld_o), 0);
      chk("R5 btb one cycle", 64'(btb_we_o), 0);
   endtask

   task automatic t_vimm_big_slot1();
      apply(1, 32'h100, w_plain(), w_pfx(1, 0, 3, 3, 63));
      chk("R3 slot1 start", 64'(slot_start_o), 2'b11);
      chk("R3 slot1 long", 64'(slot_long_o), 2'b10);
      apply(0, 32'h0, w_plain(), w_plain());
      chk("R5 redir big", 64'(redir_vld_o), 1);
      chk("R4 big target", 64'(redir_pc_o), 64'(32'h104 + exp_len(0, 3, 3, 63)));
      chk("R6 big btb_pc", 64'(btb_pc_o), 32'h104);
      apply(1, 32'h200, w_plain(), w_plain());
      chk("R8 suffix cleared", 64'(slot_start_o), 2'b11);
      chk("R5 big one cycle", 64'(redir_vld_o), 0);
   endtask

   task automatic t_vimm_mixed();
      apply(1, 32'h300, w_pfx(1, 2, 3, 2, 4), w_plain());
      apply(0, 32'h0, w_plain(), w_plain());
      chk("R4 mixed target", 64'(redir_pc_o), 64'(32'h300 + exp_len(2, 3, 2, 4)));
      chk("R4 mixed redir", 64'(redir_vld_o), 1);
   endtask

   task automatic t_vimm_short();
      apply(1, 32'h400, w_pfx(1, 3, 3, 0, 0), w_plain());
      chk("R3 short start", 64'(slot_start_o), 2'b01);
      apply(1, 32'h408, w_plain(), w_plain());
      chk("R7 no redir", 64'(redir_vld_o), 0);
      chk("R7 no flush", 64'(flush_o), 0);
      chk("R6 short btb_we", 64'(btb_we_o), 1);
      chk("R6 short btb_tgt", 64'(btb_tgt_o), 32'h408);
      chk("R7 group kept", 64'(slot_start_o), 2'b11);
      apply(1, 32'h500, w_plain(), w_pfx(1, 2, 2, 0, 0));
      apply(1, 32'h508, w_plain(), w_plain());
      chk("R7 no redir 16b", 64'(redir_vld_o), 0);
      chk("R6 btb_pc 16b", 64'(btb_pc_o), 32'h504);
      chk("R6 btb_tgt 16b", 64'(btb_tgt_o), 32'h50C);
      chk("R2 suffix after short", 64'(slot_start_o), 2'b10);
      apply(0, 32'h0, w_plain(), w_plain());
   endtask

   task automatic t_idle();
      apply(0, 32'h600, w_pfx(1, 0, 0, 3, 7), w_plain());
      chk("R9 no marks", 64'(slot_start_o), 2'b00);
      apply(0, 32'h0, w_plain(), w_plain());
      chk("R9 no btb", 64'(btb_we_o), 0);
      chk("R9 no redir", 64'(redir_vld_o), 0);
   endtask

   task automatic t_back_to_back();
      apply(1, 32'h700, w_pfx(1, 1, 1, 0, 3), w_plain());
      apply(1, 32'h708, w_pfx(1, 0, 0, 0, 0), w_plain());
      chk("R8 first redir", 64'(redir_vld_o), 1);
      chk("R4 first target", 64'(redir_pc_o), 64'(32'h700 + exp_len(1, 1, 0, 3)));
      chk("R8 second squashed", 64'(slot_start_o), 2'b00);
      apply(0, 32'h0, w_plain(), w_plain());
      chk("R8 no second redir", 64'(redir_vld_o), 0);
      chk("R8 no second btb", 64'(btb_we_o), 0);
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      t_reset();
      t_plain();
      t_prefix();
      t_vimm_slot0();
      t_vimm_big_slot1();
      t_vimm_mixed();
      t_vimm_short();
      t_idle();
      t_back_to_back();
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule